// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital conversion-control sequencer of a successive-approximation converter. An active-low start request is brought into the system clock domain. Its falling edge launches a conversion of fixed length, counted in clock cycles. Once a conversion is under way it always runs to its end: neither a new start edge nor the power-down input can cut it short or restart it. When the conversion ends, BUSY drops. On that same edge the result word offered on an input port is copied into the output register, and a one-cycle ready pulse is raised.

After every conversion the block times a minimum acquisition window. If the start request is still held low when that window closes, the next conversion begins on the spot. A start line tied low therefore keeps the converter running back-to-back with no further edges. Power-down stops this chaining at the next acquisition boundary, and while the block is idle it refuses all start requests. Out of reset the block waits for a first falling edge and converts nothing until then.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset the block stays idle with busy, acq_phase, conv_phase and data_rdy low and result_out zero, and it starts no conversion until start_n shows a falling edge. A falling edge taken from idle raises busy SYNC_STAGES+1 clock edges after start_n changes.
- R2: Every conversion keeps busy high for exactly CONV_CYCLES clock cycles, and conv_phase follows busy.
- R3: Raising pwrdn during a conversion neither shortens nor ends it.
- R4: A falling edge on start_n while busy is high is ignored. It does not reload the conversion timer, and it does not cause a later conversion once start_n is high again by the end of acquisition.
- R5: Each conversion is followed by an acquisition window of exactly ACQ_CYCLES cycles with acq_phase high. If the synchronized start_n is low and pwrdn is low when that window ends, the next conversion begins with no edge, so busy is low for exactly ACQ_CYCLES cycles between conversions.
- R6: On the clock edge where busy falls, result_out takes the value of result_in and data_rdy is high for exactly that one following cycle. data_rdy is low at all other times.
- R7: While idle, pwrdn high blocks every start request. pwrdn high at the end of an acquisition window stops automatic restarting. After pwrdn is released, a fresh falling edge on start_n starts a conversion.
- R8: busy and acq_phase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low conversion start request, asynchronous to clk |
| pwrdn | input | 1 | Power-down request, active high |
| result_in | input | RES_W | Conversion result supplied by the analog core |
| busy | output | 1 | High throughout the convert phase |
| conv_phase | output | 1 | Convert phase indication |
| acq_phase | output | 1 | Timed acquisition window indication |
| result_out | output | RES_W | Result register, loaded when busy falls |
| data_rdy | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench targets the corners where a sequencer usually breaks. Power-down raised mid-conversion would shorten busy if abort were possible. A second start edge during busy would either stretch the conversion or queue a phantom conversion. A start line held low would show an acquisition gap that is off by one cycle. Power-down would fail to stop the automatic chain. A capture taken one edge early or late would show up as a result_out mismatch when busy falls, or as a data_rdy pulse longer than one cycle. Random start pulses of varied length, some of which land inside the acquisition window, keep the width and capture checks running on every conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2
  } phase_e;

  // Value loaded into a down-counter so that a phase lasts 'cycles' clocks.
  function automatic int unsigned span_load(input int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  // Counter width able to hold the longer of two phase loads.
  function automatic int unsigned span_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_n,
  output logic req_sync_n,
  output logic req_fall
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= req_async_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{1'b1}};
        else        chain <= {chain[STAGES-2:0], req_async_n};
      end
    end
  endgenerate

  assign req_sync_n = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= req_sync_n;
  end

  assign req_fall = prev_q & ~req_sync_n;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rdy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      rdy <= 1'b0;
    end else begin
      rdy <= capture;
      if (capture) q <= d;
    end
  end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W       = 16,
  parameter int unsigned CONV_CYCLES = 12,
  parameter int unsigned ACQ_CYCLES  = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             pwrdn,
  input  logic [RES_W-1:0] result_in,
  output logic             busy,
  output logic             conv_phase,
  output logic             acq_phase,
  output logic [RES_W-1:0] result_out,
  output logic             data_rdy
);

  localparam int unsigned CW = span_bits(CONV_CYCLES, ACQ_CYCLES);
  localparam logic [CW-1:0] CONV_LOAD = CW'(span_load(CONV_CYCLES));
  localparam logic [CW-1:0] ACQ_LOAD  = CW'(span_load(ACQ_CYCLES));

  phase_e        state, state_nx;
  logic          start_s_n, start_fall;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val, tmr_cnt;
  logic          capture;

  // Named events for the assertions
  logic conv_end, acq_end, auto_go, idle_go;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_async_n(start_n),
    .req_sync_n (start_s_n),
    .req_fall   (start_fall)
  );

  adc_seq_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .count   (tmr_cnt),
    .expired (tmr_expired)
  );

  adc_seq_capture #(.W(RES_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .d      (result_in),
    .q      (result_out),
    .rdy    (data_rdy)
  );

  assign conv_end = (state == PH_CONV) && tmr_expired;
  assign acq_end  = (state == PH_ACQ)  && tmr_expired;
  assign auto_go  = acq_end && !start_s_n && !pwrdn;
  assign idle_go  = (state == PH_IDLE) && start_fall && !pwrdn;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (idle_go) begin
          state_nx = PH_CONV;
          tmr_load = 1'b1;
          tmr_val  = CONV_LOAD;
        end
      end
      PH_CONV: begin
        if (conv_end) begin
          state_nx = PH_ACQ;
          tmr_load = 1'b1;
          tmr_val  = ACQ_LOAD;
          capture  = 1'b1;
        end
      end
      PH_ACQ: begin
        if (auto_go) begin
          state_nx = PH_CONV;
          tmr_load = 1'b1;
          tmr_val  = CONV_LOAD;
        end else if (acq_end) begin
          state_nx = PH_IDLE;
        end
      end
      default: state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= state_nx;
  end

  assign busy       = (state == PH_CONV);
  assign conv_phase = busy;
  assign acq_phase  = (state == PH_ACQ);

  // R1: a conversion begins only from an idle start edge or an auto restart
  a_r1_start_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start_fall) || $past(acq_phase)));

  // R3: a running conversion is never abandoned before its timer ends
  a_r3_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_end) |=> busy);

  // R4: a start edge inside a conversion does not reload the timer
  a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_end) |=> (tmr_cnt == $past(tmr_cnt) - 1'b1));

  // R5: start still low at the end of acquisition chains a new conversion
  a_r5_auto_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_phase && tmr_expired && !start_s_n && !pwrdn) |=> busy);

  // R6: result captured on the edge where busy falls
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (data_rdy && result_out == $past(result_in)));

  // R6: ready is a single-cycle pulse
  a_r6_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |=> !data_rdy);

  // R7: power-down while idle keeps the block out of conversion
  a_r7_pwrdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_IDLE) && pwrdn) |=> !busy);

  // R8: phases exclusive
  a_r8_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && acq_phase));

endmodule

// File: tb/adc_conv_sequencer_bench.sv
`timescale 1ns/1ps
module adc_conv_sequencer_bench;

  localparam int RES_W = 16;
  localparam int CONV  = 12;
  localparam int ACQ   = 20;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_n = 1'b1;
  logic             pwrdn = 1'b0;
  logic [RES_W-1:0] result_in = '0;
  logic             busy, conv_phase, acq_phase, data_rdy;
  logic [RES_W-1:0] result_out;

  int checks = 0;
  int failures = 0;
  int starts = 0;
  int busy_run = 0;
  bit prev_busy = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_conv_sequencer #(
    .RES_W(RES_W), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ), .SYNC_STAGES(SYNC)
  ) u_adc_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwrdn(pwrdn),
    .result_in(result_in), .busy(busy), .conv_phase(conv_phase),
    .acq_phase(acq_phase), .result_out(result_out), .data_rdy(data_rdy)
  );

  // Expected values from the requirements
  function automatic int exp_latency();   return SYNC + 1; endfunction
  function automatic int exp_conv_width(); return CONV; endfunction
  function automatic int exp_acq_gap();   return ACQ; endfunction
  function automatic int exp_result(input int v); return v; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  // Continuous monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(busy && acq_phase), "R8 phase exclusion", int'(busy && acq_phase), 0);
      if (conv_phase != busy) chk(1'b0, "R2 conv_phase follows busy", int'(conv_phase), int'(busy));
      if (busy) busy_run++;
      if (busy && !prev_busy) starts++;
      if (!busy && prev_busy) begin
        chk(busy_run == exp_conv_width(), "R2 busy width", busy_run, exp_conv_width());
        chk(data_rdy == 1'b1, "R6 data_rdy at busy fall", int'(data_rdy), 1);
        chk(int'(result_out) == exp_result(int'(result_in)), "R6 result capture",
            int'(result_out), exp_result(int'(result_in)));
        busy_run = 0;
      end else if (data_rdy) begin
        chk(1'b0, "R6 data_rdy outside busy fall", 1, 0);
      end
      prev_busy = busy;
    end
  end

  task automatic wait_busy(input int limit, output int n);
    n = 0;
    while (!busy && n < limit) begin cyc(); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy || acq_phase) && n < 1000) begin cyc(); n++; end
  endtask

  // Random result word changes, only at drive time
  task automatic new_result();
    result_in = RES_W'($urandom());
  endtask

  initial begin
    int n, s0, gap, acqc;
    void'($urandom(32'h5EED_0017));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    chk(!busy && !acq_phase && !conv_phase && !data_rdy, "R1 reset outputs",
        int'({busy, acq_phase, conv_phase, data_rdy}), 0);
    chk(result_out == '0, "R1 reset result", int'(result_out), 0);
    repeat (40) begin new_result(); cyc(); end
    chk(starts == 0, "R1 no conversion without edge", starts, 0);

    // R1: start latency
    new_result();
    start_n = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); n++;
      if (busy) break;
    end
    #1;
    chk(n == exp_latency(), "R1 start latency", n, exp_latency());

    // R5: held low -> auto chaining with exact acquisition gap
    for (int k = 0; k < 3; k++) begin
      while (busy) cyc();
      gap = 0; acqc = 0;
      while (!busy && gap < 200) begin
        if (acq_phase) acqc++;
        gap++; new_result(); cyc();
      end
      chk(gap == exp_acq_gap(), "R5 auto gap", gap, exp_acq_gap());
      chk(acqc == exp_acq_gap(), "R5 acq_phase width", acqc, exp_acq_gap());
    end
    start_n = 1'b1;
    wait_idle();
    repeat (10) cyc();

    // R3: power-down mid-conversion does not shorten it; R7: stops chaining
    start_n = 1'b0;
    wait_busy(50, n);
    repeat (3) cyc();
    pwrdn = 1'b1;
    n = 3;
    while (busy) begin n++; cyc(); end
    chk(n == exp_conv_width(), "R3 width under pwrdn", n, exp_conv_width());
    s0 = starts;
    repeat (ACQ + 30) cyc();
    chk(starts == s0, "R7 pwrdn stops auto restart", starts - s0, 0);
    start_n = 1'b1;
    repeat (5) cyc();
    start_n = 1'b0; repeat (5) cyc(); start_n = 1'b1;
    repeat (30) cyc();
    chk(starts == s0 && !busy, "R7 pwrdn blocks idle start", starts - s0, 0);
    pwrdn = 1'b0;
    repeat (5) cyc();
    chk(starts == s0, "R7 release alone does not start", starts - s0, 0);
    start_n = 1'b0; repeat (4) cyc(); start_n = 1'b1;
    wait_busy(50, n);
    chk(busy == 1'b1, "R7 fresh edge after release", int'(busy), 1);
    wait_idle();
    repeat (5) cyc();

    // R4: edge during busy ignored
    s0 = starts;
    start_n = 1'b0;
    wait_busy(50, n);
    start_n = 1'b1;
    repeat (2) cyc();
    start_n = 1'b0; repeat (3) cyc(); start_n = 1'b1;
    n = 5;
    while (busy) begin n++; cyc(); end
    chk(n == exp_conv_width(), "R4 width with extra edge", n, exp_conv_width());
    wait_idle();
    repeat (40) cyc();
    chk(starts - s0 == 1, "R4 no phantom conversion", starts - s0, 1);

    // Random pulses, monitor checks width and capture
    for (int it = 0; it < 60; it++) begin
      int hold = 1 + int'($urandom_range(0, 40));
      int idle = int'($urandom_range(0, 30));
      start_n = 1'b0;
      for (int j = 0; j < hold; j++) begin new_result(); cyc(); end
      start_n = 1'b1;
      for (int j = 0; j < idle; j++) begin new_result(); cyc(); end
    end
    wait_idle();
    repeat (10) cyc();
    chk(starts > 20, "R2 random conversions seen", starts, 21);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule